// File: doc/BRIEF.md
# Operand Forwarding and Pipeline Stall Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. Each cycle it compares the source register numbers of the instruction in decode and of the instruction in execute against the destination registers held in the three downstream pipeline latches. From those comparisons it chooses where each execute operand comes from, and it decides whether the decode instruction must be held back.

The two operand selects feed one mux per operand. The ALU and the branch comparator both take their inputs through these muxes, so a forwarded value reaches a branch compare as well as an arithmetic operation. When a hold is needed, `stall` freezes the program counter and the fetch/decode latch, and `bubble` loads a no-op into the decode/execute latch.

Two run-time mode inputs enable forwarding and hazard detection independently. The number of bubbles for a dependency depends on the mode. With forwarding on, an ALU result costs nothing and a load result costs one bubble. With forwarding off, any adjacent dependency costs two bubbles. With hazard detection off, the block never holds the pipeline and software must pad the code.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: With `fwd_en`=1, an execute source that matches a writing, non-load instruction in the execute/memory latch selects code 1 (execute/memory value). Nothing matches when that latch's write enable is 0.
- R2: When the execute/memory latch and the memory/writeback latch both match a source, code 1 wins over code 2.
- R3: With `fwd_en`=1, a source that matches only a writing memory/writeback latch selects code 2 (memory/writeback value).
- R4: A load in the execute/memory latch is never forwarded from there, because it holds an address. The select falls back to code 2 if the memory/writeback latch matches, and to code 0 otherwise.
- R5: With `ZERO_HARDWIRED`=1, register number 0 never produces a forward select and never causes a stall.
- R6: With `fwd_en`=0, both selects are code 0 (register file).
- R7: With `fwd_en`=1 and `hd_en`=1, `stall` is 1 only when the execute-stage instruction is a writing load whose destination matches a decode source. A load-use pair therefore costs exactly one bubble, and an ALU-use pair costs none.
- R8: With `fwd_en`=0 and `hd_en`=1, `stall` is 1 when a writing instruction in the execute stage or in the execute/memory latch matches a decode source. A match in the memory/writeback latch alone never stalls. An adjacent dependency therefore costs two bubbles.
- R9: With `hd_en`=0, `stall` and `bubble` are always 0, and the forward selects keep working.
- R10: `bubble` equals `stall` in every cycle.
- R11: `sel_a` and `sel_b` are computed independently from `ex_rs1` and `ex_rs2`. They only take codes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | Forwarding mode enable |
| hd_en | input | 1 | Hazard detection mode enable |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_rs1 | input | REG_AW | First source register of the execute instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_we | input | 1 | The execute instruction writes a register |
| ex_load | input | 1 | The execute instruction is a load |
| mem_rd | input | REG_AW | Destination register in the execute/memory latch |
| mem_we | input | 1 | The execute/memory latch entry writes a register |
| mem_load | input | 1 | The execute/memory latch entry is a load |
| wb_rd | input | REG_AW | Destination register in the memory/writeback latch |
| wb_we | input | 1 | The memory/writeback latch entry writes a register |
| sel_a | output | 2 | Operand A source: 0 register file, 1 execute/memory, 2 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding as sel_a |
| stall | output | 1 | Hold the program counter and the fetch/decode latch |
| bubble | output | 1 | Load a no-op into the decode/execute latch |

## Verification
The embedded assertions check the following on every evaluation:
- Disabling forwarding forces register-file selects.
- A load address in the execute/memory latch never reaches an operand.
- Register 0 never selects a forwarded value.
- Hazard detection off never stalls.
- A stall always has a writing producer behind it.

Some properties are only visible over several cycles, so only the bench's scenarios can show them. The bench walks a producer/consumer pair through a modelled pipeline in all four mode combinations. It checks the bubble count in each mode: 0 or 1 with forwarding, 2 and 2 without. It also checks which latch supplies the operand once the consumer enters execute. Select priority and the handling of disabled write enables are covered by the vector table.

// File: rtl/hz_ctl_pkg.sv
package hz_ctl_pkg;

   // Operand source codes shared by ALU and branch comparator muxes
   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_MEM = 2'd1,
      SEL_WB  = 2'd2
   } opsel_e;

   localparam int OPS_PER_INSN = 2;

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
   import hz_ctl_pkg::*;
#(
   parameter int REG_AW         = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic              fwd_en,
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_we,
   input  logic              mem_load,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_we,
   output opsel_e            sel
);

   logic src_live;
   logic mem_hit;
   logic wb_hit;

   generate
      if (ZERO_HARDWIRED) begin : g_zero_reg
         assign src_live = (src != '0);
      end else begin : g_all_regs
         assign src_live = 1'b1;
      end
   endgenerate

   // A load in the execute/memory latch carries an address, not data
   assign mem_hit = fwd_en & src_live & mem_we & ~mem_load & (mem_rd == src);
   assign wb_hit  = fwd_en & src_live & wb_we & (wb_rd == src);

   // Younger producer first
   always_comb begin
      if (mem_hit)     sel = SEL_MEM;
      else if (wb_hit) sel = SEL_WB;
      else             sel = SEL_RF;
   end

   always_comb begin
      AST_FWD_OFF_USES_RF: assert (fwd_en || sel == SEL_RF)
         else $error("forward select active while forwarding disabled"); // R6
      AST_NO_LOAD_ADDR_FWD: assert (!(sel == SEL_MEM && mem_load))
         else $error("load address forwarded from execute/memory latch"); // R4
      AST_ZERO_NOT_FWD: assert (!(ZERO_HARDWIRED && src == '0 && sel != SEL_RF))
         else $error("register zero forwarded"); // R5
   end

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl #(
   parameter int REG_AW         = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic              fwd_en,
   input  logic              hd_en,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_we,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_we,
   output logic              stall
);

   function automatic logic reg_hit(input logic [REG_AW-1:0] rd,
                                    input logic              we,
                                    input logic [REG_AW-1:0] rs);
      return we && (rd == rs) && (!ZERO_HARDWIRED || rs != '0);
   endfunction

   logic ex_match;
   logic mem_match;
   logic need_hold;

   assign ex_match  = reg_hit(ex_rd, ex_we, id_rs1) | reg_hit(ex_rd, ex_we, id_rs2);
   assign mem_match = reg_hit(mem_rd, mem_we, id_rs1) | reg_hit(mem_rd, mem_we, id_rs2);

   // Forwarding covers all but load-use; without it wait for writeback,
   // which writes the register file early in the cycle
   always_comb begin
      if (fwd_en) need_hold = ex_match & ex_load;
      else        need_hold = ex_match | mem_match;
   end

   assign stall = hd_en & need_hold;

   always_comb begin
      AST_HD_OFF_NO_STALL: assert (hd_en || !stall)
         else $error("stall raised with hazard detection off"); // R9
      AST_STALL_HAS_PRODUCER: assert (!stall || ex_we || mem_we)
         else $error("stall without a writing producer"); // R8
   end

endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
   import hz_ctl_pkg::*;
#(
   parameter int REG_AW         = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic              fwd_en,
   input  logic              hd_en,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic [REG_AW-1:0] ex_rs1,
   input  logic [REG_AW-1:0] ex_rs2,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_we,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_we,
   input  logic              mem_load,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_we,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic              stall,
   output logic              bubble
);

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_width
         $error("REG_AW must lie between 1 and 8");
      end
   endgenerate

   logic [REG_AW-1:0] ex_src [OPS_PER_INSN];
   opsel_e            op_sel [OPS_PER_INSN];

   assign ex_src[0] = ex_rs1;
   assign ex_src[1] = ex_rs2;

   generate
      for (genvar i = 0; i < OPS_PER_INSN; i++) begin : g_operand
         hz_fwd_sel #(
            .REG_AW         (REG_AW),
            .ZERO_HARDWIRED (ZERO_HARDWIRED)
         ) u_sel (
            .fwd_en   (fwd_en),
            .src      (ex_src[i]),
            .mem_rd   (mem_rd),
            .mem_we   (mem_we),
            .mem_load (mem_load),
            .wb_rd    (wb_rd),
            .wb_we    (wb_we),
            .sel      (op_sel[i])
         );
      end
   endgenerate

   assign sel_a = op_sel[0];
   assign sel_b = op_sel[1];

   hz_stall_ctl #(
      .REG_AW         (REG_AW),
      .ZERO_HARDWIRED (ZERO_HARDWIRED)
   ) u_stall (
      .fwd_en  (fwd_en),
      .hd_en   (hd_en),
      .id_rs1  (id_rs1),
      .id_rs2  (id_rs2),
      .ex_rd   (ex_rd),
      .ex_we   (ex_we),
      .ex_load (ex_load),
      .mem_rd  (mem_rd),
      .mem_we  (mem_we),
      .stall   (stall)
   );

   // The no-op is injected in the same cycle the front end holds
   assign bubble = stall;

endmodule

// File: tb/hz_pipe_ctrl_tb.sv
module hz_pipe_ctrl_tb;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       fwd_en = 0, hd_en = 0;
   logic [4:0] id_rs1 = 0, id_rs2 = 0, ex_rs1 = 0, ex_rs2 = 0;
   logic [4:0] ex_rd = 0, mem_rd = 0, wb_rd = 0;
   logic       ex_we = 0, ex_load = 0, mem_we = 0, mem_load = 0, wb_we = 0;
   logic [1:0] sel_a, sel_b;
   logic       stall, bubble;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   hz_pipe_ctrl u_dut (
      .fwd_en, .hd_en, .id_rs1, .id_rs2, .ex_rs1, .ex_rs2,
      .ex_rd, .ex_we, .ex_load, .mem_rd, .mem_we, .mem_load,
      .wb_rd, .wb_we, .sel_a, .sel_b, .stall, .bubble
   );

   typedef struct packed {
      bit fwd; bit hd;
      logic [4:0] id1; logic [4:0] id2; logic [4:0] e1; logic [4:0] e2;
      logic [4:0] erd; bit ewe; bit eld;
      logic [4:0] mrd; bit mwe; bit mld;
      logic [4:0] wrd; bit wwe;
      logic [1:0] ea; logic [1:0] eb; bit es;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{1,1,  0, 0,  3, 4,  0,0,0,  3,1,0,  4,1,  1,2, 0}, // R1 R3 R11
      '{1,1,  0, 0,  5, 5,  0,0,0,  5,1,0,  5,1,  1,1, 0}, // R2
      '{1,1,  0, 0,  6, 7,  0,0,0,  6,1,1,  6,1,  2,0, 0}, // R4
      '{1,1,  0, 0,  0, 0,  0,1,1,  0,1,0,  0,1,  0,0, 0}, // R5
      '{0,1,  8, 0,  3, 0,  8,1,0,  3,1,0,  0,0,  0,0, 1}, // R6 R8
      '{0,1,  0, 9,  9, 0,  0,0,0,  9,1,0,  0,0,  0,0, 1}, // R8
      '{0,1, 10, 0,  0, 0,  0,0,0,  0,0,0, 10,1,  0,0, 0}, // R8
      '{1,1, 11, 0,  0, 0, 11,1,1,  0,0,0,  0,0,  0,0, 1}, // R7
      '{1,1,  0,12,  0, 0, 12,1,0,  0,0,0,  0,0,  0,0, 0}, // R7
      '{1,1, 13, 0,  0, 0,  0,0,0, 13,1,1,  0,0,  0,0, 0}, // R7
      '{0,0,  8, 0,  0, 0,  8,1,0,  8,1,0,  0,0,  0,0, 0}, // R9
      '{1,0,  2, 0,  2, 0,  2,1,1,  2,1,0,  0,0,  1,0, 0}, // R9
      '{1,1, 14, 0,  0, 0, 14,0,1,  0,0,0,  0,0,  0,0, 0}, // R7
      '{1,1,  0, 0,  0,15,  0,0,0, 15,0,0,  0,0,  0,0, 0}  // R1
   };

   function automatic string vec_req(input int i);
      case (i)
         0: return "R1/R3/R11";  1: return "R2";   2: return "R4";
         3: return "R5";         4: return "R6/R8"; 5: return "R8";
         6: return "R8";         7: return "R7";   8: return "R7";
         9: return "R7";         10: return "R9";  11: return "R9";
         12: return "R7";        default: return "R1";
      endcase
   endfunction

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [4:0] rd; logic [4:0] rs1; logic we; logic ld;
   } stg_t;

   localparam stg_t NOP = '{0, 0, 0, 0};

   task automatic drive_pipe(input stg_t id_s, input stg_t ex_s, input stg_t mem_s, input stg_t wb_s);
      @(negedge clk);
      id_rs1 = id_s.rs1; id_rs2 = 0;
      ex_rs1 = ex_s.rs1; ex_rs2 = 0;
      ex_rd = ex_s.rd; ex_we = ex_s.we; ex_load = ex_s.ld;
      mem_rd = mem_s.rd; mem_we = mem_s.we; mem_load = mem_s.ld;
      wb_rd = wb_s.rd; wb_we = wb_s.we;
      #2;
   endtask

   // Producer writes x7, consumer reads x7 in the next slot
   task automatic run_pair(input bit f, input bit h, input bit is_load,
                           input int exp_bubbles, input int exp_sel, input string req);
      stg_t prod, cons, ex_s, mem_s, wb_s;
      int bubbles;
      prod = '{7, 1, 1, is_load};
      cons = '{3, 7, 1, 0};
      ex_s = prod; mem_s = NOP; wb_s = NOP;
      bubbles = 0;
      fwd_en = f; hd_en = h;
      for (int c = 0; c < 5; c++) begin
         drive_pipe(cons, ex_s, mem_s, wb_s);
         if (!stall) break;
         check_eq(req, "bubble tracks stall (R10)", bubble, 1);
         wb_s = mem_s; mem_s = ex_s; ex_s = NOP;
         bubbles++;
      end
      check_eq(req, $sformatf("bubble count f=%0d h=%0d ld=%0d", f, h, is_load), bubbles, exp_bubbles);
      wb_s = mem_s; mem_s = ex_s; ex_s = cons;
      drive_pipe(NOP, ex_s, mem_s, wb_s);
      check_eq(req, "consumer operand select", sel_a, exp_sel);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // Reset state: everything idle, modes on
      fwd_en = 1; hd_en = 1;
      @(negedge clk); #2;
      check_eq("R6", "idle sel_a", sel_a, 0);
      check_eq("R6", "idle sel_b", sel_b, 0);
      check_eq("R9", "idle stall", stall, 0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         fwd_en = TBL[i].fwd; hd_en = TBL[i].hd;
         id_rs1 = TBL[i].id1; id_rs2 = TBL[i].id2;
         ex_rs1 = TBL[i].e1; ex_rs2 = TBL[i].e2;
         ex_rd = TBL[i].erd; ex_we = TBL[i].ewe; ex_load = TBL[i].eld;
         mem_rd = TBL[i].mrd; mem_we = TBL[i].mwe; mem_load = TBL[i].mld;
         wb_rd = TBL[i].wrd; wb_we = TBL[i].wwe;
         #2;
         check_eq(vec_req(i), $sformatf("vec %0d sel_a", i), sel_a, TBL[i].ea);
         check_eq(vec_req(i), $sformatf("vec %0d sel_b", i), sel_b, TBL[i].eb);
         check_eq(vec_req(i), $sformatf("vec %0d stall", i), stall, TBL[i].es);
         check_eq("R10", $sformatf("vec %0d bubble", i), bubble, TBL[i].es);
      end

      // Mode sweep over a dependent pair
      run_pair(1, 1, 0, 0, 1, "R1 R7");
      run_pair(1, 1, 1, 1, 2, "R7 R3");
      run_pair(0, 1, 0, 2, 0, "R8 R6");
      run_pair(0, 1, 1, 2, 0, "R8 R6");
      run_pair(1, 0, 0, 0, 1, "R9 R1");
      run_pair(1, 0, 1, 0, 0, "R9 R4");
      run_pair(0, 0, 0, 0, 0, "R9 R6");
      run_pair(0, 0, 1, 0, 0, "R9 R6");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule